// File: doc/BRIEF.md
# Program ROM Readout Port

This block lets an external tester dump the contents of an on-chip program ROM through pins that have other jobs in normal operation. While the readout-enable input is high and the reset pin is held low, the block is in read mode and keeps the data bus released. The tester places a 10-bit address on the pins: the low eight bits on the data bus and the upper two bits on the two lowest lines of the second port. It then raises the reset pin. That rising edge captures the address. For as long as reset stays high, the block drives the addressed ROM byte onto all eight data bus lines.

The reset pin therefore does three jobs: it holds the part in read mode, it strobes the address, and it enables the output. All pins are sampled by the block clock. The bidirectional bus is split into an input, an output and an output enable, which the pad ring combines. The ROM has 1024 bytes and its contents come from a constant formula.

Top module: `rom_readout_port`

## Requirements
- R1: After the block reset `rstN` is released, `busOe` is 0 and stays 0 until a read cycle completes.
- R2: The captured address is `{hiAddr[1:0], busIn[7:0]}`: `hiAddr` supplies address bits 9..8 and `busIn` supplies bits 7..0.
- R3: An address is captured only on the first clock edge that sees `strobeIn` high, and only if the edge before it saw `readEn` high with `strobeIn` low. A rising `strobeIn` that does not follow such a read-mode cycle causes no drive.
- R4: `busOe` rises after the clock edge that follows the capturing edge, and never earlier.
- R5: Whenever `strobeIn` is low, `busOe` is 0 in that same cycle.
- R6: When `readEn` falls, `busOe` drops to 0 in that same cycle. Raising `readEn` again while `strobeIn` stays high does not restart the drive; a new low-then-high cycle of `strobeIn` is needed.
- R7: Changes on `busIn` or `hiAddr` after the capturing edge have no effect on `busOut` while `strobeIn` stays high.
- R8: The ROM byte at address a is (lo*29 + hi*83 + 5) mod 256, where lo = a[7:0] and hi = a[9:8].
- R9: While `strobeIn` stays high, the drive and the byte persist. A different address is read only after `strobeIn` goes low and rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| readEn | input | 1 | Readout enable (logic form of the high-voltage enable) |
| strobeIn | input | 1 | Reset pin: low holds read mode; its rise strobes the address and keeps the output enabled |
| busIn | input | 8 | Data bus as seen by the block (address bits 7..0) |
| hiAddr | input | 2 | Two lowest lines of the second port (address bits 9..8) |
| busOut | output | 8 | Byte to drive on the data bus |
| busOe | output | 1 | Output enable for the data bus pads |

## Verification
The drive is due on a fixed schedule. The first clock edge that sees `strobeIn` high captures the address, and `busOe` and `busOut` are valid after the next edge. Disabling is combinational, so the drive drops in the same cycle that `strobeIn` or `readEn` goes low. The bench changes inputs on falling edges and samples 1 ns later, so it checks the captured-but-not-yet-driving cycle separately from the driving cycle. It checks the immediate release right after the input that forces it. After the capturing edge it scrambles the address pins, so any late sampling of the address shows up as a wrong byte.

// File: rtl/romrd_pkg.sv
package romrd_pkg;

  typedef struct packed {
    logic latchAddr;
    logic loadData;
  } rdStrobe_t;

  function automatic logic [31:0] romWord(input int unsigned idx);
    int unsigned lo;
    int unsigned hi;
    lo = idx % 256;
    hi = idx / 256;
    return 32'((lo * 29 + hi * 83 + 5) % 256);
  endfunction

endpackage

// File: rtl/romrd_ctrl.sv
module romrd_ctrl
  import romrd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       readEn,
  input  logic       strobeIn,
  output rdStrobe_t  sb,
  output logic       oeCtl
);

  logic enLowQ;
  logic pendQ;
  logic driveQ;
  logic riseSeen;

  assign riseSeen     = strobeIn & enLowQ & readEn;
  assign sb.latchAddr = riseSeen;
  assign sb.loadData  = pendQ & strobeIn & readEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enLowQ <= 1'b0;
      pendQ  <= 1'b0;
      driveQ <= 1'b0;
    end else begin
      enLowQ <= readEn & ~strobeIn;
      pendQ  <= riseSeen;
      if (!strobeIn || !readEn)
        driveQ <= 1'b0;
      else if (sb.loadData)
        driveQ <= 1'b1;
    end
  end

  assign oeCtl = driveQ & strobeIn & readEn;

  // R3: a capture needs a read-mode cycle just before it
  a_r3_latch_after_mode: assert property (@(posedge clk) disable iff (!rstN)
    sb.latchAddr |-> $past(readEn && !strobeIn));

  // R4: data load only in the edge after a capture
  a_r4_load_after_latch: assert property (@(posedge clk) disable iff (!rstN)
    sb.loadData |-> $past(sb.latchAddr));

endmodule

// File: rtl/romrd_datapath.sv
module romrd_datapath
  import romrd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rdStrobe_t                sb,
  input  logic [DATA_W-1:0]        busIn,
  input  logic [ADDR_W-DATA_W-1:0] hiAddr,
  output logic [DATA_W-1:0]        dataOut
);

  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] romArr [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign romArr[i] = DATA_W'(romWord(i));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (sb.latchAddr)
        addrQ <= {hiAddr[HI_W-1:0], busIn};
      if (sb.loadData)
        dataQ <= romArr[addrQ];
    end
  end

  assign dataOut = dataQ;

  // R2: captured address follows the pins seen at the capture edge
  a_r2_addr_capture: assert property (@(posedge clk) disable iff (!rstN)
    sb.latchAddr |=> addrQ == $past({hiAddr, busIn}));

  // R7: address holds between captures
  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sb.latchAddr |=> $stable(addrQ));

endmodule

// File: rtl/rom_readout_port.sv
module rom_readout_port
  import romrd_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     readEn,
  input  logic                     strobeIn,
  input  logic [DATA_W-1:0]        busIn,
  input  logic [ADDR_W-DATA_W-1:0] hiAddr,
  output logic [DATA_W-1:0]        busOut,
  output logic                     busOe
);

  rdStrobe_t sb;
  logic      oeCtl;

  romrd_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .readEn   (readEn),
    .strobeIn (strobeIn),
    .sb       (sb),
    .oeCtl    (oeCtl)
  );

  romrd_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sb      (sb),
    .busIn   (busIn),
    .hiAddr  (hiAddr),
    .dataOut (busOut)
  );

  assign busOe = oeCtl;

  // R5: bus released while the strobe pin is low
  a_r5_release_low: assert property (@(posedge clk) disable iff (!rstN)
    !strobeIn |-> !busOe);

  // R6: bus released whenever readout is disabled
  a_r6_release_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !readEn |-> !busOe);

  // R4: no drive on the first edge that sees the strobe high
  a_r4_no_early_drive: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strobeIn) |-> !busOe);

endmodule

// File: tb/tb_rom_readout_port.sv
module tb_rom_readout_port;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       readEn = 1'b0;
  logic       strobeIn = 1'b1;
  logic [7:0] busIn = '0;
  logic [1:0] hiAddr = '0;
  logic [7:0] busOut;
  logic       busOe;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rom_readout_port dut (
    .clk(clk), .rstN(rstN), .readEn(readEn), .strobeIn(strobeIn),
    .busIn(busIn), .hiAddr(hiAddr), .busOut(busOut), .busOe(busOe)
  );

  function automatic int expByte(input int a);
    int lo;
    int hi;
    lo = a & 255;
    hi = (a >> 8) & 3;
    return (lo * 29 + hi * 83 + 5) & 255;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // full read cycle; returns with strobe low, readEn high
  task automatic doRead(input int addr);
    @(negedge clk);
    readEn = 1'b1; strobeIn = 1'b0;
    busIn = 8'(addr); hiAddr = 2'(addr >> 8);
    #1 chk("R5 released in read mode", busOe, 0);
    tick();
    strobeIn = 1'b1;
    #1 chk("R4 no drive before capture", busOe, 0);
    tick();
    busIn = 8'($urandom); hiAddr = 2'($urandom);
    #1 chk("R4 no drive on capture edge", busOe, 0);
    tick();
    chk("R4 drive after next edge", busOe, 1);
    chk("R2 R8 R7 byte", busOut, expByte(addr));
    busIn = 8'($urandom); hiAddr = 2'($urandom);
    tick();
    chk("R9 drive persists", busOe, 1);
    chk("R9 R7 byte persists", busOut, expByte(addr));
    strobeIn = 1'b0;
    #1 chk("R5 release on strobe low", busOe, 0);
  endtask

  initial begin
    process::self().srandom(32'd20240611);
    #35;
    chk("R1 reset idle", busOe, 0);
    rstN = 1'b1;
    tick(); tick();
    chk("R1 idle after reset", busOe, 0);

    // directed corners
    doRead(0);
    doRead(1023);
    doRead(255);
    doRead(256);

    // R3: strobe rises while readout disabled
    tick();
    readEn = 1'b0; strobeIn = 1'b0; busIn = 8'h12; hiAddr = 2'd1;
    tick();
    strobeIn = 1'b1;
    tick();
    readEn = 1'b1;
    tick(); tick();
    chk("R3 no capture without read mode", busOe, 0);

    // R3: enable raised while strobe already high
    readEn = 1'b0;
    tick();
    readEn = 1'b1;
    tick(); tick(); tick();
    chk("R3 no capture without strobe rise", busOe, 0);

    // R6: drop enable during drive
    strobeIn = 1'b0;
    tick();
    busIn = 8'h34; hiAddr = 2'd2;
    tick();
    strobeIn = 1'b1;
    tick(); tick();
    chk("R6 drive before disable", busOe, 1);
    readEn = 1'b0;
    #1 chk("R6 immediate release", busOe, 0);
    tick();
    readEn = 1'b1;
    #1 chk("R6 no resume on re-enable", busOe, 0);
    tick(); tick();
    chk("R6 still released", busOe, 0);
    strobeIn = 1'b0;

    // constrained random reads
    for (int i = 0; i < 40; i++) begin
      doRead(int'($urandom_range(1023, 0)));
      if ($urandom_range(3, 0) == 0) begin
        tick();
        chk("R5 idle between reads", busOe, 0);
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule